// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and turns event pulses from six on-chip sources into subroutine call requests aimed at fixed program addresses. The sources are a USB engine (which can fire on any of four bus events), two timers that signal overflow, a serial port, an audio playback path and an audio capture path. Each pulse is captured in a sticky request flag. A flag turns into a call request only when its own enable bit and a shared master enable are both set and the core reports that its return-address stack still has room.

Software reaches the block through two byte-wide control words. Each word holds both enable bits and request flags. When the core takes a call, the controller clears the flag it served and also drops the master enable. Further interrupts therefore stay blocked until the service routine sets the master enable again, which is how nesting is allowed. A separate wake-up output is raised whenever any flag is pending, whatever the enable bits say.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, both control words read 0x00, `call_req` is 0 and `wake_req` is 0.
- R2: Word A at address 0x0B reads {0, t1 flag, t0 flag, usb flag, t1 enable, t0 enable, usb enable, master} from bit 7 down to bit 0. Word B at address 0x1E reads {0, record flag, serial flag, play flag, 0, record enable, serial enable, play enable}. Any other read address returns 0x00.
- R3: An event pulse sets its source's flag on the next clock edge, whatever the enables and the master say. Any one of the four `usb_evt` bits sets the USB flag.
- R4: `call_req` is 1 exactly when the master enable is 1, the stack is not full, and at least one source has both its flag and its enable at 1.
- R5: When several sources are eligible, the lowest index wins. The order is USB, timer 0, timer 1, serial, play, record, with vectors 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. `call_vec` reads 0x00 when there is no request.
- R6: When `call_take` is 1 while `call_req` is 1, the next edge clears the served flag and the master enable and leaves all other flags and enables unchanged.
- R7: A hardware set and a software write of 0 to the same flag in the same cycle leave the flag at 1.
- R8: `wake_req` is 1 exactly when at least one of the six flags is set.
- R9: While `stack_full` is 1 no call is requested, and pending flags stay set; the request appears once `stack_full` returns to 0.
- R10: A write to a control word loads its enable, master and flag bits directly, so software can both set and clear flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control words |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| usb_evt | input | 4 | USB event pulses: FIFO access, suspend, resume, bus reset |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| ser_evt | input | 1 | Serial port event pulse |
| play_evt | input | 1 | Playback event pulse |
| rec_evt | input | 1 | Capture event pulse |
| stack_full | input | 1 | Return-address stack has no free entry |
| call_take | input | 1 | Core accepts the current call request this cycle |
| call_req | output | 1 | Call request to the core |
| call_vec | output | 8 | Target address of the requested call |
| wake_req | output | 1 | Wake-up request, set while any flag is pending |

## Verification
The assertions assume that `call_take` means something only in a cycle where `call_req` is high. They also assume that `stack_full` and the event pulses are free to change in any cycle, with no ordering between them. The random stimulus drives `call_take` without regard to `call_req`, so takes that should be ignored also occur. It raises events with a low probability, so flags build up over several cycles, and it sends writes to both control words and to unused addresses. Directed sequences force the collision between a hardware set and a software clear, hold the stack full while a request is pending, and fill every flag at once to exercise the priority order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC   = 6;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_WORD_A = 8'h0B;
    localparam logic [ADDR_W-1:0] ADDR_WORD_B = 8'h1E;

    // Source indices; a lower index has higher priority
    localparam int SRC_USB  = 0;
    localparam int SRC_T0   = 1;
    localparam int SRC_T1   = 2;
    localparam int SRC_SER  = 3;
    localparam int SRC_PLAY = 4;
    localparam int SRC_REC  = 5;

    typedef struct packed {
        logic            master;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } irq_state_t;

    // Vector table: four bytes per source, starting at 0x04
    function automatic logic [DATA_W-1:0] vec_of(input int idx);
        return DATA_W'((idx + 1) * 4);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSRC-1:0]   hw_set,
    input  logic [NSRC-1:0]   ack_clr,
    output irq_state_t        st,
    output logic [DATA_W-1:0] rd_data
);

    irq_state_t st_nxt;

    always_comb begin
        st_nxt = st;
        if (wr_en && wr_addr == ADDR_WORD_A) begin
            st_nxt.master        = wr_data[0];
            st_nxt.en[SRC_USB]   = wr_data[1];
            st_nxt.en[SRC_T0]    = wr_data[2];
            st_nxt.en[SRC_T1]    = wr_data[3];
            st_nxt.flag[SRC_USB] = wr_data[4];
            st_nxt.flag[SRC_T0]  = wr_data[5];
            st_nxt.flag[SRC_T1]  = wr_data[6];
        end
        if (wr_en && wr_addr == ADDR_WORD_B) begin
            st_nxt.en[SRC_PLAY]   = wr_data[0];
            st_nxt.en[SRC_SER]    = wr_data[1];
            st_nxt.en[SRC_REC]    = wr_data[2];
            st_nxt.flag[SRC_PLAY] = wr_data[4];
            st_nxt.flag[SRC_SER]  = wr_data[5];
            st_nxt.flag[SRC_REC]  = wr_data[6];
        end
        // Acceptance beats a software write; a hardware event beats both
        if (|ack_clr) begin
            st_nxt.master = 1'b0;
        end
        st_nxt.flag = (st_nxt.flag & ~ack_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_WORD_A: rd_data = {1'b0, st.flag[SRC_T1], st.flag[SRC_T0],
                                    st.flag[SRC_USB], st.en[SRC_T1],
                                    st.en[SRC_T0], st.en[SRC_USB], st.master};
            ADDR_WORD_B: rd_data = {1'b0, st.flag[SRC_REC], st.flag[SRC_SER],
                                    st.flag[SRC_PLAY], 1'b0, st.en[SRC_REC],
                                    st.en[SRC_SER], st.en[SRC_PLAY]};
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      pend,
    input  logic              gate,
    output logic [N-1:0]      grant,
    output logic              any,
    output logic [DATA_W-1:0] vec
);

    logic [N-1:0] elig;
    logic [N:0]   taken;

    assign elig     = gate ? pend : '0;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_prio
        assign grant[i]   = elig[i] & ~taken[i];
        assign taken[i+1] = taken[i] | elig[i];
    end

    assign any = taken[N];

    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                vec = vec_of(i);
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [3:0]        usb_evt,
    input  logic [1:0]        tmr_ovf,
    input  logic              ser_evt,
    input  logic              play_evt,
    input  logic              rec_evt,
    input  logic              stack_full,
    input  logic              call_take,
    output logic              call_req,
    output logic [DATA_W-1:0] call_vec,
    output logic              wake_req
);

    irq_state_t      st;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] ack_clr;
    logic            master_q;
    logic [NSRC-1:0] flag_q;

    always_comb begin
        hw_set           = '0;
        hw_set[SRC_USB]  = |usb_evt;
        hw_set[SRC_T0]   = tmr_ovf[0];
        hw_set[SRC_T1]   = tmr_ovf[1];
        hw_set[SRC_SER]  = ser_evt;
        hw_set[SRC_PLAY] = play_evt;
        hw_set[SRC_REC]  = rec_evt;
    end

    assign ack_clr = call_take ? grant : '0;

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .hw_set  (hw_set),
        .ack_clr (ack_clr),
        .st      (st),
        .rd_data (rd_data)
    );

    irqc_arb #(.N(NSRC)) u_arb (
        .pend  (st.flag & st.en),
        .gate  (st.master & ~stack_full),
        .grant (grant),
        .any   (call_req),
        .vec   (call_vec)
    );

    assign master_q = st.master;
    assign flag_q   = st.flag;
    assign wake_req = |st.flag;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              call_req,
    input logic              call_take,
    input logic [DATA_W-1:0] call_vec,
    input logic              stack_full,
    input logic              master,
    input logic [NSRC-1:0]   flags,
    input logic [NSRC-1:0]   hw_set
);

    p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        stack_full |-> !call_req);

    p_req_needs_master_r4: assert property (@(posedge clk) disable iff (rst)
        call_req |-> master);

    p_req_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (|flags));

    p_take_drops_master_r6: assert property (@(posedge clk) disable iff (rst)
        (call_req && call_take) |=> !master);

    p_vec_legal_r5: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_vec[1:0] == 2'b00 && call_vec >= 8'h04 &&
                      call_vec <= DATA_W'(4 * NSRC)));

    p_idle_vec_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !call_req |-> (call_vec == '0));

    p_event_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

endmodule

bind irqc_top irqc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .call_req   (call_req),
    .call_take  (call_take),
    .call_vec   (call_vec),
    .stack_full (stack_full),
    .master     (master_q),
    .flags      (flag_q),
    .hw_set     (hw_set)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [3:0] usb_evt;
    logic [1:0] tmr_ovf;
    logic       ser_evt, play_evt, rec_evt, stack_full, call_take;
    logic       call_req, wake_req;
    logic [7:0] call_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state, index order: usb, t0, t1, ser, play, rec
    logic       m_master;
    logic [5:0] m_en, m_flag;

    always #4 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .usb_evt(usb_evt), .tmr_ovf(tmr_ovf), .ser_evt(ser_evt),
        .play_evt(play_evt), .rec_evt(rec_evt), .stack_full(stack_full),
        .call_take(call_take), .call_req(call_req), .call_vec(call_vec),
        .wake_req(wake_req)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] eligible();
        return (m_master && !stack_full) ? (m_en & m_flag) : 6'd0;
    endfunction

    function automatic logic [7:0] exp_vec();
        logic [5:0] e = eligible();
        for (int i = 0; i < 6; i++) if (e[i]) return 8'((i + 1) * 4);
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h0B)
            return {1'b0, m_flag[2], m_flag[1], m_flag[0], m_en[2], m_en[1], m_en[0], m_master};
        if (a == 8'h1E)
            return {1'b0, m_flag[5], m_flag[3], m_flag[4], 1'b0, m_en[5], m_en[3], m_en[4]};
        return 8'h00;
    endfunction

    task automatic set_idle();
        wr_en = 0; wr_addr = 8'h00; wr_data = 8'h00; rd_addr = 8'h0B;
        usb_evt = 0; tmr_ovf = 0; ser_evt = 0; play_evt = 0; rec_evt = 0;
        stack_full = 0; call_take = 0;
    endtask

    // Inputs are already driven (after a negedge); compare, then advance the model
    task automatic step();
        logic       n_master;
        logic [5:0] n_en, n_flag, hw, clr, e;
        #1;
        check8("R4 call_req", {7'd0, call_req}, {7'd0, |eligible()});
        check8("R5 call_vec", call_vec, exp_vec());
        check8("R8 wake_req", {7'd0, wake_req}, {7'd0, |m_flag});
        check8("R2 rd_data", rd_data, exp_rd(rd_addr));
        n_master = m_master; n_en = m_en; n_flag = m_flag;
        if (wr_en && wr_addr == 8'h0B) begin
            n_master = wr_data[0];
            n_en[2:0] = wr_data[3:1];
            n_flag[2:0] = wr_data[6:4];
        end
        if (wr_en && wr_addr == 8'h1E) begin
            n_en[4] = wr_data[0]; n_en[3] = wr_data[1]; n_en[5] = wr_data[2];
            n_flag[4] = wr_data[4]; n_flag[3] = wr_data[5]; n_flag[5] = wr_data[6];
        end
        e = eligible();
        clr = 6'd0;
        if (call_take) clr = e & (~e + 6'd1);
        if (|clr) n_master = 1'b0;
        hw = {rec_evt, play_evt, ser_evt, tmr_ovf[1], tmr_ovf[0], |usb_evt};
        n_flag = (n_flag & ~clr) | hw;
        @(posedge clk);
        m_master = n_master; m_en = n_en; m_flag = n_flag;
        @(negedge clk);
        set_idle();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic peek(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check8(tag, rd_data, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        set_idle();
        m_master = 0; m_en = 0; m_flag = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        peek("R1 word A", 8'h0B, 8'h00);
        peek("R1 word B", 8'h1E, 8'h00);
        check8("R1 call_req", {7'd0, call_req}, 8'h00);
        check8("R1 wake_req", {7'd0, wake_req}, 8'h00);

        // R3: resume event, everything disabled
        usb_evt = 4'b0100; step();
        peek("R3 usb flag", 8'h0B, 8'h10);
        check8("R8 wake on flag", {7'd0, wake_req}, 8'h01);
        tmr_ovf = 2'b10; step();
        peek("R3 t1 flag", 8'h0B, 8'h50);

        // R10: software clears the flags
        do_write(8'h0B, 8'h00);
        peek("R10 clear word A", 8'h0B, 8'h00);
        check8("R8 wake idle", {7'd0, wake_req}, 8'h00);

        // R7: play event beats a software clear in the same cycle
        play_evt = 1; wr_en = 1; wr_addr = 8'h1E; wr_data = 8'h00; step();
        peek("R7 play flag kept", 8'h1E, 8'h10);

        // R9: enable play and master, hold the stack full
        do_write(8'h1E, 8'h11);
        stack_full = 1; wr_en = 1; wr_addr = 8'h0B; wr_data = 8'h01; step();
        stack_full = 1; #1;
        check8("R9 held while full", {7'd0, call_req}, 8'h00);
        peek("R9 flag pending", 8'h1E, 8'h11);
        stack_full = 0; #1;
        check8("R9 released", {7'd0, call_req}, 8'h01);
        check8("R5 play vector", call_vec, 8'h14);

        // R6: take clears the served flag and the master
        call_take = 1; step();
        peek("R6 play flag cleared", 8'h1E, 8'h01);
        peek("R6 master cleared", 8'h0B, 8'h00);

        // R5: every source pending, walk the priority order
        do_write(8'h1E, 8'h77);
        do_write(8'h0B, 8'h7F);
        #1; check8("R5 usb first", call_vec, 8'h04);
        call_take = 1; step();
        peek("R6 only usb cleared", 8'h0B, 8'h6E);
        check8("R6 no request", {7'd0, call_req}, 8'h00);
        do_write(8'h0B, 8'h6F);
        #1; check8("R5 t0 next", call_vec, 8'h08);
        do_write(8'h0B, 8'h0F);
        #1; check8("R5 serial after timers", call_vec, 8'h10);
        do_write(8'h1E, 8'h57);
        #1; check8("R5 play after serial", call_vec, 8'h14);
        do_write(8'h1E, 8'h47);
        #1; check8("R5 record last", call_vec, 8'h18);

        // Random traffic against the reference model
        for (int c = 0; c < 4000; c++) begin
            int r;
            usb_evt    = (($urandom % 16) == 0) ? 4'($urandom) : 4'd0;
            tmr_ovf[0] = (($urandom % 10) == 0);
            tmr_ovf[1] = (($urandom % 10) == 0);
            ser_evt    = (($urandom % 12) == 0);
            play_evt   = (($urandom % 12) == 0);
            rec_evt    = (($urandom % 12) == 0);
            stack_full = (($urandom % 4) == 0);
            call_take  = (($urandom % 2) == 0);
            r = $urandom % 8;
            wr_en   = (r < 3);
            wr_addr = (r == 0) ? 8'h0B : (r == 1) ? 8'h1E : 8'($urandom);
            wr_data = 8'($urandom);
            if (wr_en && wr_addr == 8'h0B && ($urandom % 2) == 0) wr_data[0] = 1'b1;
            r = $urandom % 5;
            rd_addr = (r < 2) ? 8'h0B : (r < 4) ? 8'h1E : 8'($urandom);
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule